// File: doc/BRIEF.md
# Multi-Width Integer ALU with Status Flags

This block is the integer execute stage of a small 32-bit two-operand machine. The destination operand is also the first operand, and the result goes back into it. A one-cycle `go` strobe starts an operation. The strobe carries an opcode, a size select (byte, 16-bit word or 32-bit long), a source operand and the current destination value. One clock later the block presents the 32-bit value to write back, a write-enable, and a four-bit status register.

Only the low 8, 16 or 32 bits take part in the operation. When the size is byte or word, the bits above the selected width are copied unchanged from the incoming destination into the returned value. Compare sets the flags and never writes. Flags are computed at the selected width, so the sign flag comes from bit 7, 15 or 31.

Top module: `mw_alu`

## Requirements
- R1: The size select `sz` picks the operand width: 0 means byte (bits 7:0), 1 means word (bits 15:0), 2 or 3 means long (bits 31:0). Bits of `result` above the selected width equal the same bits of `dst`.
- R2: Opcode 0 (add) returns dst+src. Opcode 1 (subtract) returns dst−src. For add, C is the carry out of the selected width. For subtract, C is the borrow. V is the signed overflow at that width.
- R3: Opcode 2 (compare) forms dst−src. It sets Z, N, C and V exactly as subtract does. It drives `wr_en` low and leaves `result` unchanged.
- R4: Opcode 3 (increment) returns dst+1, with C and V as for an add. Opcode 4 (decrement) returns dst−1, with C and V as for a subtract. Opcode 5 (negate) returns 0−dst, with C set when the selected dst bits are nonzero and V set when they hold the most negative value. None of these uses `src`.
- R5: Opcodes 6, 7, 8 and 9 return dst AND src, dst OR src, dst XOR src, and NOT dst. Each of them clears C and V.
- R6: Opcode 10 shifts dst left and opcode 11 shifts it arithmetically right, replicating bit 7, 15 or 31 of the selected width. The shift count is `src[4:0]`. Both opcodes clear C and V.
- R7: A shift whose masked count is zero writes back dst unchanged and leaves all four flags at their previous values.
- R8: `flags` is {V, C, N, Z}, with Z in bit 0, N in bit 1, C in bit 2 and V in bit 3. Z is set when the selected-width result is zero. N is the top bit of the selected-width result.
- R9: Outputs change only on the clock edge that samples `go` high, and they are visible in the following cycle. `wr_en` is high for exactly that one cycle. Opcodes 12 to 15 write nothing and leave the flags unchanged.
- R10: After reset, `result` is 0, `wr_en` is 0 and `flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start an operation this cycle |
| op | input | 4 | Operation code |
| sz | input | 2 | Operand width select |
| src | input | 32 | Source operand or shift count |
| dst | input | 32 | Current destination value |
| result | output | 32 | Value to write back into the destination |
| wr_en | output | 1 | Write back `result` this cycle |
| flags | output | 4 | Status {V, C, N, Z} |

## Verification
The checker assumes that `op`, `sz`, `src` and `dst` are stable and meaningful only in a cycle where `go` is high. It also assumes they are held long enough for `$past` to see them on the edge that samples `go`. The width-dependent flag properties look back at the sampled size, opcode and count, so they rely on each request lasting exactly one cycle. The bench respects these assumptions. It drives each request on a falling edge, drops `go` at the next falling edge, and keeps only in-range opcodes and sizes while `go` is high.

// File: rtl/mw_alu.sv
module mw_alu #(
  parameter int XLEN = 32,
  parameter int OPW  = 4,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [OPW-1:0]  op,
  input  logic [1:0]      sz,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic [3:0]      flags
);
  localparam logic [OPW-1:0] OP_ADD = 0, OP_SUB = 1, OP_CMP = 2, OP_INC = 3,
                             OP_DEC = 4, OP_NEG = 5, OP_AND = 6, OP_OR = 7,
                             OP_XOR = 8, OP_NOT = 9, OP_SHL = 10, OP_SAR = 11;
  localparam int FZ = 0, FN = 1, FC = 2, FV = 3;

  logic [XLEN-1:0] wmask, a, b, sext, r, res_w, merged;
  logic [XLEN:0]   sum, dif, inc, dec, ng;
  logic [5:0]      msb;
  logic [CNTW-1:0] cnt;
  logic            a_s, b_s, r_s, c, v, we, upd;

  always_comb begin
    case (sz)
      2'd0:    begin wmask = XLEN'('hFF);   msb = 6'd7;  end
      2'd1:    begin wmask = XLEN'('hFFFF); msb = 6'd15; end
      default: begin wmask = '1;            msb = 6'(XLEN-1); end
    endcase
  end

  assign a   = dst & wmask;
  assign b   = src & wmask;
  assign cnt = src[CNTW-1:0];
  assign a_s = a[msb];
  assign b_s = b[msb];
  assign sum = {1'b0, a} + {1'b0, b};
  assign dif = {1'b0, a} - {1'b0, b};
  assign inc = {1'b0, a} + 1'b1;
  assign dec = {1'b0, a} - 1'b1;
  assign ng  = '0 - {1'b0, a};

  always_comb begin
    case (sz)
      2'd0:    sext = {{(XLEN-8){dst[7]}}, dst[7:0]};
      2'd1:    sext = {{(XLEN-16){dst[15]}}, dst[15:0]};
      default: sext = dst;
    endcase
  end

  always_comb begin
    r = a; c = 1'b0; v = 1'b0; we = 1'b1; upd = 1'b1;
    case (op)
      OP_ADD: begin
        r = sum[XLEN-1:0]; c = sum[msb+1];
        v = (a_s == b_s) && (sum[msb] != a_s);
      end
      OP_SUB, OP_CMP: begin
        r = dif[XLEN-1:0]; c = dif[msb+1];
        v = (a_s != b_s) && (dif[msb] != a_s);
        we = (op != OP_CMP);
      end
      OP_INC: begin
        r = inc[XLEN-1:0]; c = inc[msb+1];
        v = !a_s && inc[msb];
      end
      OP_DEC: begin
        r = dec[XLEN-1:0]; c = (a == '0);
        v = a_s && !dec[msb];
      end
      OP_NEG: begin
        r = ng[XLEN-1:0]; c = (a != '0);
        v = a_s && ng[msb];
      end
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_NOT: r = ~a;
      OP_SHL: begin r = a << cnt; upd = (cnt != '0); end
      OP_SAR: begin r = XLEN'($signed(sext) >>> cnt); upd = (cnt != '0); end
      default: begin we = 1'b0; upd = 1'b0; end
    endcase
  end

  assign res_w  = r & wmask;
  assign merged = (dst & ~wmask) | res_w;
  assign r_s    = res_w[msb];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      flags  <= '0;
    end else begin
      wr_en <= go && we;
      if (go && we) result <= merged;
      if (go && upd) begin
        flags[FZ] <= (res_w == '0);
        flags[FN] <= r_s;
        flags[FC] <= c;
        flags[FV] <= v;
      end
    end
  end
endmodule

// File: rtl/mw_alu_chk.sv
module mw_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic [3:0]  op,
  input logic [1:0]  sz,
  input logic [31:0] src,
  input logic [31:0] dst,
  input logic [31:0] result,
  input logic        wr_en,
  input logic [3:0]  flags
);
  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // R3
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 4'd2) |=> (!wr_en && $stable(result)));

  // R1
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sz == 2'd0 && op < 4'd12 && op != 4'd2) |=> (result[31:8] == $past(dst[31:8])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!wr_en && $stable(flags) && $stable(result)));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op >= 4'd12) |=> (!wr_en && $stable(flags)));

  // R7
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op == 4'd10 || op == 4'd11) && src[4:0] == 5'd0) |=> ($stable(flags) && result == $past(dst)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op < 4'd12 && op != 4'd2 && !((op == 4'd10 || op == 4'd11) && src[4:0] == 5'd0))
    |=> (flags[0] == ((result & msk($past(sz))) == 32'd0)));

  // R6
  shift_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op == 4'd10 || op == 4'd11) && src[4:0] != 5'd0) |=> (flags[3:2] == 2'b00));
endmodule

bind mw_alu mw_alu_chk u_chk (.*);

// File: tb/mw_alu_tb.sv
`timescale 1ns/1ps
module mw_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  sz = '0;
  logic [31:0] src = '0, dst = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mw_alu u_dut (.clk(clk), .rst_n(rst_n), .go(go), .op(op), .sz(sz), .src(src),
                .dst(dst), .result(result), .wr_en(wr_en), .flags(flags));

  localparam int NV = 19;
  // {req, op, sz, src, dst, expected result, expected flags VCNZ, expected wr_en}
  localparam logic [110:0] VECS [NV] = '{
    {4'd2, 4'd0,  2'd2, 32'h1,        32'h2,        32'h3,        4'b0000, 1'b1}, // R2
    {4'd1, 4'd0,  2'd0, 32'h1,        32'hAABBCCFF, 32'hAABBCC00, 4'b0101, 1'b1}, // R1 carry
    {4'd2, 4'd0,  2'd1, 32'h1,        32'h12347FFF, 32'h12348000, 4'b1010, 1'b1}, // R2 overflow
    {4'd2, 4'd1,  2'd2, 32'h7,        32'h5,        32'hFFFFFFFE, 4'b0110, 1'b1}, // R2 borrow
    {4'd3, 4'd2,  2'd2, 32'h7,        32'h7,        32'h0,        4'b0001, 1'b0}, // R3 equal
    {4'd3, 4'd2,  2'd0, 32'h1,        32'h80,       32'h0,        4'b1000, 1'b0}, // R3 overflow
    {4'd4, 4'd3,  2'd0, 32'h0,        32'h0000017F, 32'h00000180, 4'b1010, 1'b1}, // R4 inc
    {4'd4, 4'd4,  2'd1, 32'h0,        32'hFFFF0000, 32'hFFFFFFFF, 4'b0110, 1'b1}, // R4 dec
    {4'd4, 4'd5,  2'd2, 32'h0,        32'h1,        32'hFFFFFFFF, 4'b0110, 1'b1}, // R4 neg
    {4'd4, 4'd5,  2'd0, 32'h0,        32'h12345680, 32'h12345680, 4'b1110, 1'b1}, // R4 neg min
    {4'd5, 4'd6,  2'd2, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h0,        4'b0001, 1'b1}, // R5 and
    {4'd5, 4'd7,  2'd1, 32'h00008001, 32'hABCD0010, 32'hABCD8011, 4'b0010, 1'b1}, // R5 or
    {4'd5, 4'd8,  2'd0, 32'hFF,       32'h11223355, 32'h112233AA, 4'b0010, 1'b1}, // R5 xor
    {4'd5, 4'd9,  2'd2, 32'h0,        32'hFFFFFFFF, 32'h0,        4'b0001, 1'b1}, // R5 not
    {4'd6, 4'd10, 2'd0, 32'h1,        32'h000000C1, 32'h00000082, 4'b0010, 1'b1}, // R6 shl
    {4'd6, 4'd11, 2'd0, 32'h3,        32'hFFFFFF90, 32'hFFFFFFF2, 4'b0010, 1'b1}, // R6 sar byte
    {4'd6, 4'd11, 2'd1, 32'h24,       32'h00008000, 32'h0000F800, 4'b0010, 1'b1}, // R6 sar word
    {4'd8, 4'd10, 2'd2, 32'h1F,       32'h1,        32'h80000000, 4'b0010, 1'b1}, // R8 sign
    {4'd8, 4'd10, 2'd0, 32'h8,        32'h000000FF, 32'h0,        4'b0001, 1'b1}  // R8 zero
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [31:0] sv, input logic [31:0] dv);
    @(negedge clk);
    op = o; sz = s; src = sv; dst = dv; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R10", "result", result, 32'h0);
    chk("R10", "wr_en", {31'd0, wr_en}, 32'h0);
    chk("R10", "flags", {28'd0, flags}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [110:0] vv;
      string rq;
      vv = VECS[i];
      rq = $sformatf("R%0d", vv[110:107]);
      run(vv[106:103], vv[102:101], vv[100:69], vv[68:37]);
      if (vv[0]) chk(rq, "result", result, vv[36:5]);
      chk(rq, "wr_en", {31'd0, wr_en}, {31'd0, vv[0]});
      chk(rq, "flags", {28'd0, flags}, {28'd0, vv[4:1]});
    end

    // R9: wr_en lasts one cycle
    @(negedge clk);
    chk("R9", "wr_en idle", {31'd0, wr_en}, 32'h0);

    // R7: masked zero count keeps flags
    run(4'd0, 2'd1, 32'h1, 32'h00007FFF);
    chk("R2", "flags", {28'd0, flags}, 32'hA);
    run(4'd10, 2'd2, 32'h20, 32'h0);
    chk("R7", "result", result, 32'h0);
    chk("R7", "wr_en", {31'd0, wr_en}, 32'h1);
    chk("R7", "flags", {28'd0, flags}, 32'hA);

    // R9: unassigned opcode
    run(4'd13, 2'd2, 32'h0, 32'h0);
    chk("R9", "wr_en", {31'd0, wr_en}, 32'h0);
    chk("R9", "flags", {28'd0, flags}, 32'hA);
    chk("R9", "result", result, 32'h0);

    // R6: count masked to five bits
    run(4'd11, 2'd2, 32'h21, 32'h80000000);
    chk("R6", "result", result, 32'hC0000000);
    chk("R6", "flags", {28'd0, flags}, 32'h2);

    // R3: compare leaves result untouched
    run(4'd2, 2'd2, 32'h0, 32'h0);
    chk("R3", "result", result, 32'hC0000000);
    chk("R3", "wr_en", {31'd0, wr_en}, 32'h0);
    chk("R3", "flags", {28'd0, flags}, 32'h1);

    // R1: long width via size 3
    run(4'd0, 2'd3, 32'h1, 32'hFFFFFFFF);
    chk("R1", "result", result, 32'h0);
    chk("R1", "flags", {28'd0, flags}, 32'h5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule